// File: doc/BRIEF.md
# Dual-Mode Boundary-Scan and Programming Port

This block puts two different serial engines behind a single set of four shared pins: a clock, a mode/select line, a data input and a data output. A level on `modeEn` chooses which engine owns the pins. When `modeEn` is high, the pins form an IEEE 1149.1 test access port. A full sixteen-state TAP controller steps on the rising edge of `tck`. It drives a two-bit instruction register, a one-bit bypass register and a boundary register. The boundary register holds three cells for each bidirectional pad and one cell for each input-only pad. When `modeEn` is low, the same pins drive a plain programming shifter instead. In that mode the select line and the data line are decoded together at every clock edge as hold, shift or execute.

Taking `modeEn` low releases every pad to high impedance at once. It also parks the TAP in Test-Logic-Reset, so the port always comes back to test mode in a known state. Under EXTEST the pads take their data and enable from the update stage of the boundary register. Under every other instruction they follow the core.

Top module: `dual_scan_port`

## Requirements
- R1: While `modeEn` is high, `tms`/`tdi`/`tdo` serve the TAP and the programming shifter does not change. While `modeEn` is low, they serve the shifter and the TAP stays in Test-Logic-Reset.
- R2: Driving `trstN` low resets the TAP at once, without waiting for a clock. The instruction becomes BYPASS, the pads follow `coreOut`/`coreOe`, and `tdoEn` is 0.
- R3: Five rising edges of `tck` with `tms` high, taken from any state, bring the TAP to Test-Logic-Reset with BYPASS as the current instruction.
- R4: The instruction register is two bits wide and is shifted in least significant bit first. EXTEST is 2'b00, SAMPLE is 2'b01 and BYPASS is 2'b11. Code 2'b10 selects the bypass register. Capture-IR loads 2'b01, so the first two bits shifted out are 1 and then 0.
- R5: The bypass register loads 0 in Capture-DR and adds exactly one bit of delay from `tdi` to `tdo` during Shift-DR.
- R6: The boundary register is 3*NBIDIR+NIN bits long. Bidirectional pad i owns bit 3i (captures `padIn[i]`), bit 3i+1 (captures `coreOut[i]`) and bit 3i+2 (captures `coreOe[i]`). Input pad j owns bit 3*NBIDIR+j (captures `inPin[j]`). Bit 0 sits next to `tdo`, and `tdi` enters at the top bit.
- R7: Under SAMPLE the pads keep following the core. Under EXTEST `padOut[i]` and `padOe[i]` come from update-stage bits 3i+1 and 3i+2. Those bits are loaded on the `tck` rise taken in Update-DR.
- R8: In test mode `tdo` changes only on the falling edge of `tck`. `tdoEn` is 1 only while the TAP is in Shift-DR or Shift-IR.
- R9: All bits of `padOe` go to 0 as soon as `modeEn` goes low, whatever instruction is loaded. In that mode `tdoEn` is 1.
- R10: In programming mode, `tms`=0 shifts `tdi` into the top of a PW-bit shifter on each `tck` rise. Bits arrive least significant first, and `tdo` shows shifter bit 0.
- R11: In programming mode, `tms`=1 with `tdi`=0 holds the shifter unchanged.
- R12: In programming mode, `tms`=1 with `tdi`=1 copies the shifter to `progWord` and raises `progStrobe` for exactly one cycle. The port then returns to hold or shift on the next edge.
- R13: When `modeEn` returns high, the TAP starts in Test-Logic-Reset with BYPASS loaded, even if EXTEST was active before programming mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Shared test clock / programming serial clock |
| trstN | input | 1 | Asynchronous active-low TAP reset |
| modeEn | input | 1 | High selects test mode, low selects programming mode |
| tms | input | 1 | TAP mode select / programming control |
| tdi | input | 1 | TAP data in / programming data and control |
| tdo | output | 1 | TAP data out / programming shifter out |
| tdoEn | output | 1 | Output enable for `tdo` |
| padIn | input | NBIDIR | Value seen on the bidirectional pads |
| coreOut | input | NBIDIR | Core data for the bidirectional pads |
| coreOe | input | NBIDIR | Core output enables for the bidirectional pads |
| inPin | input | NIN | Input-only pads |
| padOut | output | NBIDIR | Data driven to the bidirectional pads |
| padOe | output | NBIDIR | Output enables of the bidirectional pads |
| progWord | output | PW | Word latched by the last execute |
| progStrobe | output | 1 | One-cycle pulse after an execute |

## Verification
The bench aims at the ordering of the boundary cells. If the cell order were swapped, the captured SAMPLE vector would come out permuted, and EXTEST would drive a pad's enable from its data bit. It loads EXTEST and then leaves it in three ways: five TMS highs, an unclocked TRST, and a trip through programming mode. A design that failed to reset the instruction would keep driving the pads from the update stage. It checks that TDO does not move on the rising edge, since a design that updated TDO there would lose the first bypass bit. In programming mode it interleaves hold cycles between shift runs. It also reads the old word out on SDO while a new one goes in, which catches a shifter that moves on hold or shifts in the wrong direction.

// File: rtl/dual_scan_pkg.sv
package dual_scan_pkg;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SELDR, ST_CAPDR, ST_SHDR, ST_EX1DR, ST_PSDR, ST_EX2DR, ST_UPDR,
    ST_SELIR, ST_CAPIR, ST_SHIR, ST_EX1IR, ST_PSIR, ST_EX2IR, ST_UPIR
  } tapState_e;

  localparam int IR_W = 2;
  localparam logic [IR_W-1:0] OP_EXTEST  = 2'b00;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 2'b01;
  localparam logic [IR_W-1:0] OP_BYPASS  = 2'b11;
  localparam logic [IR_W-1:0] IR_CAPTURE = 2'b01;

  typedef struct packed {
    logic capDr;
    logic shDr;
    logic upDr;
    logic capIr;
    logic shIr;
    logic upIr;
    logic irReset;
    logic inTlr;
    logic progShift;
    logic progExec;
  } scanCtl_t;

endpackage

// File: rtl/dual_scan_ctrl.sv
module dual_scan_ctrl
  import dual_scan_pkg::*;
(
  input  logic     tck,
  input  logic     trstN,
  input  logic     modeEn,
  input  logic     tms,
  input  logic     tdi,
  output scanCtl_t ctl
);

  tapState_e state, nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_TLR:   nxt = tms ? ST_TLR   : ST_RTI;
      ST_RTI:   nxt = tms ? ST_SELDR : ST_RTI;
      ST_SELDR: nxt = tms ? ST_SELIR : ST_CAPDR;
      ST_CAPDR: nxt = tms ? ST_EX1DR : ST_SHDR;
      ST_SHDR:  nxt = tms ? ST_EX1DR : ST_SHDR;
      ST_EX1DR: nxt = tms ? ST_UPDR  : ST_PSDR;
      ST_PSDR:  nxt = tms ? ST_EX2DR : ST_PSDR;
      ST_EX2DR: nxt = tms ? ST_UPDR  : ST_SHDR;
      ST_UPDR:  nxt = tms ? ST_SELDR : ST_RTI;
      ST_SELIR: nxt = tms ? ST_TLR   : ST_CAPIR;
      ST_CAPIR: nxt = tms ? ST_EX1IR : ST_SHIR;
      ST_SHIR:  nxt = tms ? ST_EX1IR : ST_SHIR;
      ST_EX1IR: nxt = tms ? ST_UPIR  : ST_PSIR;
      ST_PSIR:  nxt = tms ? ST_EX2IR : ST_PSIR;
      ST_EX2IR: nxt = tms ? ST_UPIR  : ST_SHIR;
      ST_UPIR:  nxt = tms ? ST_SELDR : ST_RTI;
      default:  nxt = ST_TLR;
    endcase
  end

  // Programming mode parks the TAP in Test-Logic-Reset.
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)       state <= ST_TLR;
    else if (!modeEn) state <= ST_TLR;
    else              state <= nxt;
  end

  always_comb begin
    ctl.capDr     = modeEn && (state == ST_CAPDR);
    ctl.shDr      = modeEn && (state == ST_SHDR);
    ctl.upDr      = modeEn && (state == ST_UPDR);
    ctl.capIr     = modeEn && (state == ST_CAPIR);
    ctl.shIr      = modeEn && (state == ST_SHIR);
    ctl.upIr      = modeEn && (state == ST_UPIR);
    ctl.irReset   = !modeEn || (nxt == ST_TLR);
    ctl.inTlr     = (state == ST_TLR);
    ctl.progShift = !modeEn && !tms;
    ctl.progExec  = !modeEn && tms && tdi;
  end

  AST_TLR_STICKY: assert property (@(posedge tck) disable iff (!trstN)
    (modeEn && state == ST_TLR && tms) |=> (state == ST_TLR)); // R3
  AST_PROG_PARKS_TAP: assert property (@(posedge tck) disable iff (!trstN)
    !modeEn |=> (state == ST_TLR)); // R1
  AST_ONE_STROBE: assert property (@(posedge tck) disable iff (!trstN)
    $onehot0({ctl.capDr, ctl.shDr, ctl.upDr, ctl.capIr, ctl.shIr, ctl.upIr,
              ctl.progShift, ctl.progExec})); // R1

endmodule

// File: rtl/dual_scan_dp.sv
module dual_scan_dp
  import dual_scan_pkg::*;
#(
  parameter int NBIDIR = 4,
  parameter int NIN    = 2,
  parameter int PW     = 8
) (
  input  logic              tck,
  input  logic              trstN,
  input  logic              modeEn,
  input  logic              tdi,
  input  scanCtl_t          ctl,
  input  logic [NBIDIR-1:0] padIn,
  input  logic [NBIDIR-1:0] coreOut,
  input  logic [NBIDIR-1:0] coreOe,
  input  logic [NIN-1:0]    inPin,
  output logic [NBIDIR-1:0] padOut,
  output logic [NBIDIR-1:0] padOe,
  output logic              tdo,
  output logic              tdoEn,
  output logic [PW-1:0]     progWord,
  output logic              progStrobe
);

  localparam int BSR_W  = 3 * NBIDIR + NIN;
  localparam int IN_BASE = 3 * NBIDIR;

  logic [IR_W-1:0]  irShift, irReg;
  logic             bypReg;
  logic [BSR_W-1:0] bsrShift, bsrUpd, capVec;
  logic             tdoReg, tdoEnReg;
  logic [PW-1:0]    progShiftReg, progWordReg;
  logic             progStrobeReg;
  logic             selBsr, extestOn;

  assign selBsr   = (irReg == OP_EXTEST) || (irReg == OP_SAMPLE);
  assign extestOn = (irReg == OP_EXTEST);

  // Three cells per bidirectional pad, one per input pad.
  for (genvar i = 0; i < NBIDIR; i++) begin : g_bidir
    assign capVec[3*i]     = padIn[i];
    assign capVec[3*i+1]   = coreOut[i];
    assign capVec[3*i+2]   = coreOe[i];
    assign padOut[i] = extestOn ? bsrUpd[3*i+1] : coreOut[i];
    assign padOe[i]  = modeEn && (extestOn ? bsrUpd[3*i+2] : coreOe[i]);
  end
  for (genvar j = 0; j < NIN; j++) begin : g_input
    assign capVec[IN_BASE+j] = inPin[j];
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irShift <= IR_CAPTURE;
      irReg   <= OP_BYPASS;
    end else begin
      if (ctl.capIr)     irShift <= IR_CAPTURE;
      else if (ctl.shIr) irShift <= {tdi, irShift[IR_W-1:1]};
      if (ctl.irReset)   irReg <= OP_BYPASS;
      else if (ctl.upIr) irReg <= irShift;
    end
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      bypReg   <= 1'b0;
      bsrShift <= '0;
      bsrUpd   <= '0;
    end else begin
      if (ctl.capDr && !selBsr)     bypReg <= 1'b0;
      else if (ctl.shDr && !selBsr) bypReg <= tdi;
      if (ctl.capDr && selBsr)      bsrShift <= capVec;
      else if (ctl.shDr && selBsr)  bsrShift <= {tdi, bsrShift[BSR_W-1:1]};
      if (ctl.upDr && selBsr)       bsrUpd <= bsrShift;
    end
  end

  // Test data out moves on the falling edge only.
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdoReg   <= 1'b0;
      tdoEnReg <= 1'b0;
    end else begin
      if (ctl.shIr)      tdoReg <= irShift[0];
      else if (ctl.shDr) tdoReg <= selBsr ? bsrShift[0] : bypReg;
      tdoEnReg <= ctl.shIr || ctl.shDr;
    end
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      progShiftReg  <= '0;
      progWordReg   <= '0;
      progStrobeReg <= 1'b0;
    end else begin
      if (ctl.progShift) progShiftReg <= {tdi, progShiftReg[PW-1:1]};
      if (ctl.progExec)  progWordReg  <= progShiftReg;
      progStrobeReg <= ctl.progExec;
    end
  end

  assign tdo        = modeEn ? tdoReg : progShiftReg[0];
  assign tdoEn      = modeEn ? tdoEnReg : 1'b1;
  assign progWord   = progWordReg;
  assign progStrobe = progStrobeReg;

  AST_IR_IN_TLR: assert property (@(posedge tck) disable iff (!trstN)
    ctl.inTlr |-> (irReg == OP_BYPASS)); // R3
  AST_BYPASS_ZERO: assert property (@(posedge tck) disable iff (!trstN)
    (ctl.capDr && !selBsr) |=> !bypReg); // R5
  AST_HOLD_KEEPS: assert property (@(posedge tck) disable iff (!trstN)
    !ctl.progShift |=> $stable(progShiftReg)); // R11
  AST_STROBE_CAUSE: assert property (@(posedge tck) disable iff (!trstN)
    progStrobeReg |-> $past(ctl.progExec)); // R12

endmodule

// File: rtl/dual_scan_port.sv
module dual_scan_port
  import dual_scan_pkg::*;
#(
  parameter int NBIDIR = 4,
  parameter int NIN    = 2,
  parameter int PW     = 8
) (
  input  logic              tck,
  input  logic              trstN,
  input  logic              modeEn,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdoEn,
  input  logic [NBIDIR-1:0] padIn,
  input  logic [NBIDIR-1:0] coreOut,
  input  logic [NBIDIR-1:0] coreOe,
  input  logic [NIN-1:0]    inPin,
  output logic [NBIDIR-1:0] padOut,
  output logic [NBIDIR-1:0] padOe,
  output logic [PW-1:0]     progWord,
  output logic              progStrobe
);

  scanCtl_t ctl;

  dual_scan_ctrl u_ctrl (
    .tck    (tck),
    .trstN  (trstN),
    .modeEn (modeEn),
    .tms    (tms),
    .tdi    (tdi),
    .ctl    (ctl)
  );

  dual_scan_dp #(.NBIDIR(NBIDIR), .NIN(NIN), .PW(PW)) u_dp (
    .tck        (tck),
    .trstN      (trstN),
    .modeEn     (modeEn),
    .tdi        (tdi),
    .ctl        (ctl),
    .padIn      (padIn),
    .coreOut    (coreOut),
    .coreOe     (coreOe),
    .inPin      (inPin),
    .padOut     (padOut),
    .padOe      (padOe),
    .tdo        (tdo),
    .tdoEn      (tdoEn),
    .progWord   (progWord),
    .progStrobe (progStrobe)
  );

  AST_PROG_TDO_ON: assert property (@(posedge tck) disable iff (!trstN)
    !modeEn |-> tdoEn); // R9

endmodule

// File: tb/dual_scan_port_test.sv
`timescale 1ns/1ps
module dual_scan_port_test;

  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int NI = 2;
  localparam int PW = 8;
  localparam int BW = 3 * NB + NI;

  logic tck = 1'b0;
  logic trstN, modeEn, tms, tdi;
  logic tdo, tdoEn;
  logic [NB-1:0] padIn, coreOut, coreOe, padOut, padOe;
  logic [NI-1:0] inPin;
  logic [PW-1:0] progWord;
  logic progStrobe;
  int nChecks = 0;
  int nFail = 0;
  logic sEn;

  dual_scan_port #(.NBIDIR(NB), .NIN(NI), .PW(PW)) uut (
    .tck(tck), .trstN(trstN), .modeEn(modeEn), .tms(tms), .tdi(tdi),
    .tdo(tdo), .tdoEn(tdoEn), .padIn(padIn), .coreOut(coreOut),
    .coreOe(coreOe), .inPin(inPin), .padOut(padOut), .padOe(padOe),
    .progWord(progWord), .progStrobe(progStrobe)
  );

  always #(CLK_PERIOD/2) tck = ~tck;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one edge; returns tdo as seen before that rising edge.
  task automatic step(input logic m, input logic d, output logic o);
    @(negedge tck); #1;
    o = tdo; sEn = tdoEn;
    tms = m; tdi = d;
    @(posedge tck);
  endtask

  task automatic loadIr(input logic [1:0] code, output logic [1:0] cap);
    logic o;
    step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
    step(0, code[0], cap[0]);
    step(1, code[1], cap[1]);
    step(1, 0, o); step(0, 0, o);
  endtask

  task automatic scanDr(input int n, input logic [31:0] vin, output logic [31:0] vout, output logic enSeen);
    logic o;
    vout = '0;
    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int k = 0; k < n; k++) begin
      step((k == n-1), vin[k], vout[k]);
      if (k == 0) enSeen = sEn;
    end
    step(1, 0, o); step(0, 0, o);
  endtask

  function automatic logic [31:0] expCap();
    logic [31:0] v = '0;
    for (int i = 0; i < NB; i++) begin
      v[3*i] = padIn[i]; v[3*i+1] = coreOut[i]; v[3*i+2] = coreOe[i];
    end
    for (int j = 0; j < NI; j++) v[3*NB+j] = inPin[j];
    return v;
  endfunction

  task automatic testReset();
    #1;
    chk("R2 reset padOut", padOut, coreOut);
    chk("R2 reset padOe", padOe, coreOe);
    chk("R8 reset tdoEn", tdoEn, 0);
  endtask

  task automatic testBypass();
    logic o; logic [1:0] c; logic [31:0] v; logic en;
    step(0, 0, o);
    scanDr(8, 32'h000000B6, v, en);
    chk("R5 bypass delay", v[7:0], 8'h6C);
    chk("R8 tdoEn in shift", en, 1);
    loadIr(2'b10, c);
    chk("R4 capture pattern", c, 2'b01);
    scanDr(4, 32'h0000000D, v, en);
    chk("R4 spare code bypass", v[3:0], 4'hA);
  endtask

  task automatic testTdoEdge();
    logic o;
    step(1, 0, o); step(0, 0, o); step(0, 1, o);
    step(0, 1, o);
    chk("R5 first bypass bit", o, 0);
    #1;
    chk("R8 tdo steady at rise", tdo, 0);
    @(negedge tck); #1;
    chk("R8 tdo moves at fall", tdo, 1);
    step(1, 0, o); step(1, 0, o); step(0, 0, o);
  endtask

  task automatic testSample();
    logic [1:0] c; logic [31:0] v; logic en;
    loadIr(2'b01, c);
    chk("R4 sample capture", c, 2'b01);
    scanDr(BW, 32'h0, v, en);
    chk("R6 sample vector", v[BW-1:0], expCap());
    #1;
    chk("R7 sample pads core", {padOe, padOut}, {coreOe, coreOut});
  endtask

  task automatic setExtest(input logic [NB-1:0] wOut, input logic [NB-1:0] wOe);
    logic [1:0] c; logic [31:0] v, vo; logic en;
    v = '0;
    for (int i = 0; i < NB; i++) begin
      v[3*i+1] = wOut[i]; v[3*i+2] = wOe[i];
    end
    loadIr(2'b00, c);
    scanDr(BW, v, vo, en);
    #1;
  endtask

  task automatic testExtest();
    setExtest(4'b0101, 4'b1101);
    chk("R7 extest padOut", padOut, 4'b0101);
    chk("R7 extest padOe", padOe, 4'b1101);
  endtask

  task automatic testTlr();
    logic o;
    for (int k = 0; k < 5; k++) step(1, 0, o);
    #1;
    chk("R3 tlr pads core", {padOe, padOut}, {coreOe, coreOut});
    step(0, 0, o);
  endtask

  task automatic testTrst();
    logic o;
    setExtest(4'b0011, 4'b1001);
    chk("R7 extest second", {padOe, padOut}, {4'b1001, 4'b0011});
    trstN = 0; #1;
    chk("R2 trst pads core", {padOe, padOut}, {coreOe, coreOut});
    chk("R2 trst tdoEn", tdoEn, 0);
    trstN = 1;
    step(0, 0, o);
  endtask

  task automatic testProg();
    logic o; logic [7:0] sdo;
    setExtest(4'b1111, 4'b1111);
    coreOe = 4'b1111;
    @(negedge tck); #1;
    tms = 1; tdi = 0; modeEn = 0; #1;
    chk("R9 prog hi-z", padOe, 4'b0000);
    chk("R9 prog tdoEn", tdoEn, 1);
    for (int k = 0; k < 8; k++) step(0, k[0] ^ k[2] ? 1'b0 : 1'b1, o);
    // bits 1,0,1,0,0,1,0,1 => 8'hA5
    step(1, 1, o); #1;
    chk("R12 exec word", progWord, 8'hA5);
    chk("R12 strobe high", progStrobe, 1);
    step(1, 0, o); #1;
    chk("R12 strobe one cycle", progStrobe, 0);
    chk("R1 test pins ignored", padOe, 4'b0000);
    for (int k = 0; k < 4; k++) begin step(0, (k < 2), o); sdo[k] = o; end
    for (int k = 0; k < 3; k++) step(1, 0, o);
    for (int k = 0; k < 4; k++) begin step(0, (k == 0 || k == 3), o); sdo[4+k] = o; end
    chk("R10 sdo old word", sdo, 8'hA5);
    step(1, 1, o); #1;
    chk("R11 hold then exec", progWord, 8'h93);
  endtask

  task automatic testReturn();
    logic o; logic [1:0] c;
    step(1, 0, o);
    @(negedge tck); #1;
    modeEn = 1; tms = 0;
    @(posedge tck); #1;
    chk("R13 pads core after prog", {padOe, padOut}, {coreOe, coreOut});
    loadIr(2'b11, c);
    chk("R13 tap alive", c, 2'b01);
    chk("R1 word kept in test", progWord, 8'h93);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nFail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    trstN = 0; modeEn = 1; tms = 1; tdi = 0;
    coreOut = 4'b1010; coreOe = 4'b0110; padIn = 4'b0011; inPin = 2'b10;
    #(CLK_PERIOD * 3);
    trstN = 1;
    testReset();
    testBypass();
    testTdoEdge();
    testSample();
    testExtest();
    testTlr();
    testTrst();
    testProg();
    testReturn();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule